// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Error Flags

This block recovers characters from an asynchronous serial line. An external baud generator supplies a one-clock strobe at sixteen times the bit rate. The block synchronises the incoming line to the system clock and looks for a high-to-low transition. It then checks that the start bit is still low half a bit later, and samples every following bit at its centre. The character length (5 to 8 data bits) and the parity mode are set by static configuration inputs.

When a character ends, the block puts out one byte with a single-cycle valid strobe. The byte comes with three flags: parity error, framing error and break. The downstream buffer signals that it has no room on an input. If a character completes while that input is high, the character is dropped and a separate overflow strobe fires instead. Everything already presented stays unchanged.

Top module: `uart_rx_core`

## Requirements
- R1: The number of data bits is set by `cfg_len` (0 → 5, 1 → 6, 2 → 7, 3 → 8). Bits arrive least significant first and are presented right-aligned on `rx_data`, with unused upper bits zero. `rx_valid` is high for exactly one clock per accepted character.
- R2: After the line falls, it is checked again 8 ticks later. If it is high at that point, the start is discarded and no character is produced.
- R3: Each data, parity and stop bit is sampled once, 16 ticks after the previous sample, so short disturbances near bit edges have no effect. No character completes on a clock without `baud_tick`.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd` = 1 they must hold an odd number. A mismatch sets `rx_perr` for that character.
- R5: A stop bit sampled low sets `rx_ferr` for that character.
- R6: A character whose start, data, parity (if enabled) and stop samples are all low is a break. It is reported as `rx_data` = 0 with `rx_brk` = 1, `rx_ferr` = 1 and `rx_perr` = 0.
- R7: After a break or a framing error, no new start is searched for until the line has been seen high again. A line held low produces only one break report.
- R8: If `fifo_full` is high when a character completes, `rx_valid` stays low, `rx_ovf` pulses for one clock, and `rx_data` and the flags keep their previous values.
- R9: After reset, `rx_valid` and `rx_ovf` are 0 and `rx_data`, `rx_perr`, `rx_ferr`, `rx_brk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock strobe at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data bit count code (5 + value) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_full | input | 1 | Downstream buffer has no room |
| rx_valid | output | 1 | Character accepted this clock |
| rx_data | output | 8 | Last accepted character, right-aligned |
| rx_perr | output | 1 | Parity error of last character |
| rx_ferr | output | 1 | Framing error of last character |
| rx_brk | output | 1 | Last character was a break |
| rx_ovf | output | 1 | Character dropped because buffer was full |

## Verification
The main decoding path is tried with every character length, all three parity settings, deliberately wrong parity bits, and stop bits forced low. These patterns separate a wrong alignment of short characters from a parity or stop-bit decoding fault. Frames whose data bits are inverted near both bit edges show whether sampling really happens at mid-bit. A low pulse shorter than half a bit tells a false start apart from a genuine one. A long low level followed by a normal frame tells break reporting apart from re-arming on a still-low line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_PAR   = 3'd4,
        ST_STOP  = 3'd5
    } rx_state_e;

    localparam int unsigned MIN_BITS = 5;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pipe: '1};
        else        s_q <= s_d;
    end

    assign dout = s_q.pipe[STAGES-1];
endmodule

// File: rtl/urx_parity.sv
module urx_parity #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] bits,
    input  logic         pbit,
    input  logic         odd_mode,
    output logic         mismatch
);
    logic ones_odd;
    always_comb begin
        ones_odd = ^bits ^ pbit;
        mismatch = (ones_odd != odd_mode);
    end
endmodule

// File: rtl/urx_ctrl.sv
module urx_ctrl
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR    = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              fifo_full,
    output logic              o_valid,
    output logic [DATA_W-1:0] o_data,
    output logic              o_perr,
    output logic              o_ferr,
    output logic              o_brk,
    output logic              o_ovf
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              pbit;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
        logic              ovf;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [IDX_W:0]    nbits;
    logic [IDX_W:0]    shamt;
    logic [DATA_W-1:0] aligned;
    logic              par_bad;
    logic              at_mid;
    logic              at_bit;

    always_comb begin
        nbits   = (IDX_W+1)'(MIN_BITS) + (IDX_W+1)'(cfg_len);
        shamt   = (IDX_W+1)'(DATA_W) - nbits;
        aligned = s_q.shreg >> shamt;
        at_mid  = (s_q.cnt == MID_LAST);
        at_bit  = (s_q.cnt == BIT_LAST);
    end

    urx_parity #(.W(DATA_W)) u_par (
        .bits     (aligned),
        .pbit     (s_q.pbit),
        .odd_mode (cfg_par_odd),
        .mismatch (par_bad)
    );

    always_comb begin
        logic is_brk;
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.ovf   = 1'b0;
        is_brk    = 1'b0;
        if (tick) begin
            unique case (s_q.st)
                ST_HUNT: begin
                    if (line) s_d.st = ST_IDLE;
                end
                ST_IDLE: begin
                    if (!line) begin
                        s_d.st  = ST_START;
                        s_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (at_mid) begin
                        s_d.cnt = '0;
                        if (!line) begin
                            s_d.st    = ST_DATA;
                            s_d.idx   = '0;
                            s_d.shreg = '0;
                            s_d.pbit  = 1'b0;
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_bit) begin
                        s_d.cnt   = '0;
                        s_d.shreg = {line, s_q.shreg[DATA_W-1:1]};
                        if ({1'b0, s_q.idx} == nbits - 1'b1)
                            s_d.st = cfg_par_en ? ST_PAR : ST_STOP;
                        else
                            s_d.idx = s_q.idx + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_bit) begin
                        s_d.cnt  = '0;
                        s_d.pbit = line;
                        s_d.st   = ST_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_bit) begin
                        s_d.cnt = '0;
                        is_brk  = !line && (aligned == '0) &&
                                  !(cfg_par_en && s_q.pbit);
                        if (fifo_full) begin
                            s_d.ovf = 1'b1;
                        end else begin
                            s_d.valid = 1'b1;
                            s_d.data  = is_brk ? '0 : aligned;
                            s_d.perr  = cfg_par_en && par_bad && !is_brk;
                            s_d.ferr  = !line;
                            s_d.brk   = is_brk;
                        end
                        s_d.st = line ? ST_IDLE : ST_HUNT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HUNT, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign o_valid = s_q.valid;
    assign o_data  = s_q.data;
    assign o_perr  = s_q.perr;
    assign o_ferr  = s_q.ferr;
    assign o_brk   = s_q.brk;
    assign o_ovf   = s_q.ovf;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int unsigned OSR         = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              fifo_full,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk,
    output logic              rx_ovf
);
    logic line_s;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (line_s)
    );

    urx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .line        (line_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .fifo_full   (fifo_full),
        .o_valid     (rx_valid),
        .o_data      (rx_data),
        .o_perr      (rx_perr),
        .o_ferr      (rx_ferr),
        .o_brk       (rx_brk),
        .o_ovf       (rx_ovf)
    );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              fifo_full,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_perr,
    input logic              rx_ferr,
    input logic              rx_brk,
    input logic              rx_ovf
);
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r3_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_ovf) |-> $past(baud_tick));

    a_r6_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk |-> (rx_data == '0) && rx_ferr && !rx_perr);

    a_r8_ovf_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> !rx_valid);

    a_r8_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> $past(fifo_full));

    a_r8_valid_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(fifo_full));

    a_r8_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> $stable(rx_data) && $stable(rx_ferr) && $stable(rx_perr));
endmodule

bind uart_rx_core uart_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .fifo_full (fifo_full),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_perr   (rx_perr),
    .rx_ferr   (rx_ferr),
    .rx_brk    (rx_brk),
    .rx_ovf    (rx_ovf)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;
    localparam int NVEC     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       fifo_full = 1'b0;
    logic       rx_valid, rx_perr, rx_ferr, rx_brk, rx_ovf;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int nvalid = 0;
    int novf   = 0;
    logic [7:0] cap_data;
    logic cap_perr, cap_ferr, cap_brk;
    int divcnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rx_core dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .fifo_full(fifo_full), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ovf(rx_ovf)
    );

    always @(negedge clk) begin
        divcnt    <= (divcnt == TICK_DIV-1) ? 0 : divcnt + 1;
        baud_tick <= (divcnt == TICK_DIV-1);
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            nvalid   <= nvalid + 1;
            cap_data <= rx_data;
            cap_perr <= rx_perr;
            cap_ferr <= rx_ferr;
            cap_brk  <= rx_brk;
        end
        if (rst_n && rx_ovf) novf <= novf + 1;
    end

    // {len[25:24], par_en[23], par_odd[22], bad_par[21], stop[20],
    //  data[19:12], exp_data[11:4], 2'b0, exp_perr[1], exp_ferr[0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 2'b0, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h1F, 2'b0, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2C, 8'h2C, 2'b0, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55, 8'h55, 2'b0, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h81, 2'b0, 1'b1, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 2'b0, 1'b0, 1'b1},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7F, 8'h7F, 2'b0, 1'b1, 1'b1},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 2'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input bit glitch);
        for (int c = 0; c < BIT_CLK; c++) begin
            rx_in = (glitch && (c < 12 || c >= BIT_CLK-12)) ? ~b : b;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [1:0] len, input logic pen, input logic podd,
                              input logic badp, input logic stopb,
                              input logic [7:0] d, input bit glitch);
        int n;
        logic p;
        logic [7:0] m;
        n = 5 + int'(len);
        m = d & 8'(((1 << n) - 1));
        p = (^m) ^ podd ^ badp;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < n; i++) drive_bit(m[i], glitch);
        if (pen) drive_bit(p, glitch);
        drive_bit(stopb, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v0;
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(rx_valid == 0, "R9 valid", rx_valid, 0);
        chk(rx_ovf == 0, "R9 ovf", rx_ovf, 0);
        chk({rx_data, rx_perr, rx_ferr, rx_brk} == 0, "R9 data/flags",
            {rx_data, rx_perr, rx_ferr, rx_brk}, 0);
        rst_n = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);

        // vector table: R1 length/alignment, R4 parity, R5 framing
        for (int k = 0; k < NVEC; k++) begin
            logic [25:0] e;
            e = VEC[k];
            cfg_len = e[25:24]; cfg_par_en = e[23]; cfg_par_odd = e[22];
            v0 = nvalid;
            send_frame(e[25:24], e[23], e[22], e[21], e[20], e[19:12], 1'b0);
            chk(nvalid == v0 + 1, $sformatf("R1 valid count vec%0d", k), nvalid - v0, 1);
            chk(cap_data == e[11:4], $sformatf("R1 data vec%0d", k), cap_data, e[11:4]);
            chk(cap_perr == e[1], $sformatf("R4 perr vec%0d", k), cap_perr, e[1]);
            chk(cap_ferr == e[0], $sformatf("R5 ferr vec%0d", k), cap_ferr, e[0]);
            chk(cap_brk == 0, $sformatf("R6 no brk vec%0d", k), cap_brk, 0);
        end

        // R2 false start
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        v0 = nvalid;
        rx_in = 1'b0; repeat (16) @(negedge clk);
        rx_in = 1'b1; repeat (15 * BIT_CLK) @(negedge clk);
        chk(nvalid == v0, "R2 false start ignored", nvalid - v0, 0);
        send_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b0);
        chk(nvalid == v0 + 1 && cap_data == 8'hC3, "R2 frame after false start", cap_data, 8'hC3);

        // R3 mid-bit sampling with edge disturbances
        send_frame(2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h96, 1'b1);
        chk(cap_data == 8'h96 && !cap_perr && !cap_ferr, "R3 mid-bit sample",
            {cap_data, cap_perr, cap_ferr}, {8'h96, 2'b00});

        // R6 break, R7 one report then re-arm on high
        v0 = nvalid;
        rx_in = 1'b0; repeat (12 * BIT_CLK) @(negedge clk);
        chk(nvalid == v0 + 1, "R6 break reported", nvalid - v0, 1);
        chk(cap_data == 0 && cap_brk && cap_ferr && !cap_perr, "R6 break flags",
            {cap_data, cap_brk, cap_ferr, cap_perr}, {8'h00, 3'b110});
        repeat (20 * BIT_CLK) @(negedge clk);
        chk(nvalid == v0 + 1, "R7 single break report", nvalid - v0, 1);
        rx_in = 1'b1; repeat (2 * BIT_CLK) @(negedge clk);
        send_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0);
        chk(nvalid == v0 + 2 && cap_data == 8'h5A && !cap_brk, "R7 frame after break",
            cap_data, 8'h5A);

        // R8 overflow
        v0 = nvalid;
        fifo_full = 1'b1;
        send_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33, 1'b0);
        fifo_full = 1'b0;
        chk(novf == 1, "R8 ovf pulse", novf, 1);
        chk(nvalid == v0, "R8 no valid on overflow", nvalid - v0, 0);
        chk(rx_data == 8'h5A, "R8 data kept", rx_data, 8'h5A);
        send_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 1'b0);
        chk(nvalid == v0 + 1 && cap_data == 8'h0F, "R8 recovery", cap_data, 8'h0F);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule